// File: doc/BRIEF.md
# Three-Phase Gate Output Guard

This block is the last stage before the six gate-drive pins of a three-phase inverter. Each phase (U, V, W) has a high-side request and a low-side request. Requests are active-high inside the chip. The block turns each request into a pin level in the chosen polarity. It can stop the two sides of a phase from ever being on together, and it records every cycle in which both sides of a phase were asked to switch on.

An active-low trip input removes the stage from the pins without waiting for a clock, when tripping is armed. When tripping is not armed, a low trip input hands the pins over to ordinary port control. A synchronised copy of the trip input sets a sticky status bit, and software clears that bit later.

The PWM and dead-time logic upstream supply the requests. The pad ring downstream consumes the levels, the output enables and the ownership select.

Top module: `motor_gate_guard`

## Requirements
- R1: While `rst` is high, at the next clock edge all gate pins, all output enables, the clash flags and the trip status become 0. The output enables return to 1 at the first edge after `rst` falls.
- R2: With `act_high_i` = 1, each gate pin equals its request, one clock edge after the request is applied. Bit 0 is phase U, bit 1 is V and bit 2 is W.
- R3: With `act_high_i` = 0, each gate pin equals the inverse of its request, one clock edge later.
- R4: With `excl_en_i` = 1, a phase whose two requests are both 1 drives both of its pins to the inactive level on the next edge. The inactive level is 0 when active-high and 1 when active-low. Other phases are unaffected.
- R5: With `excl_en_i` = 0, a phase whose two requests are both 1 drives both pins to the active level.
- R6: `clash_o[i]` becomes 1 one edge after both requests of phase i are 1, whatever `excl_en_i` is. It stays 1 afterwards.
- R7: A 1 on `clr_clash_i[i]` clears `clash_o[i]` at the next edge. If a new clash on that phase arrives in the same cycle, the flag stays set.
- R8: While `trip_en_i` = 1 and `trip_n_i` = 0, all six output enables are 0 at once, without a clock edge. They return to 1 as soon as either condition ends.
- R9: While `trip_en_i` = 0 and `trip_n_i` = 0, `port_sel_o` is 1 (the pads take port control) and the output enables stay 1. Otherwise `port_sel_o` is 0.
- R10: While `trip_en_i` = 1, a low `trip_n_i` sets `trip_seen_o` at the third clock edge after it goes low. The bit stays set until a 1 on `clr_trip_i` clears it at the next edge.
- R11: While `trip_en_i` = 0, a low `trip_n_i` never sets `trip_seen_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_high_i | input | 1 | 1: pins active high, 0: pins active low |
| excl_en_i | input | 1 | Enable blocking of both-sides-on per phase |
| trip_en_i | input | 1 | Arm the trip input to tri-state the pins |
| trip_n_i | input | 1 | Active-low trip input |
| req_pos_i | input | 3 | High-side requests, bit 0 = U, 1 = V, 2 = W |
| req_neg_i | input | 3 | Low-side requests, same bit order |
| clr_clash_i | input | 3 | Write-one-to-clear for the clash flags |
| clr_trip_i | input | 1 | Write-one-to-clear for the trip status |
| gate_pos_o | output | 3 | High-side pin levels |
| gate_neg_o | output | 3 | Low-side pin levels |
| gate_oe_o | output | 6 | Output enables: bits 2:0 high side, bits 5:3 low side |
| port_sel_o | output | 1 | 1: pads under general-purpose port control |
| clash_o | output | 3 | Sticky per-phase both-sides-requested flags |
| trip_seen_o | output | 1 | Sticky synchronised trip status |

## Verification
Pin levels and clash flags are due one clock edge after their request. The bench therefore drives on a falling edge and samples on the next falling edge. The enable gating and the port select are combinational, so they are sampled a time step after the trip inputs change, with no clock edge in between. The trip status is due on the third rising edge. The bench checks that it is still clear after the second edge and set after the third.

// File: rtl/mgg_pkg.sv
package mgg_pkg;
  // Who owns the six gate pads.
  typedef enum logic {
    OWN_STAGE = 1'b0,
    OWN_PORT  = 1'b1
  } pad_owner_e;

  localparam int unsigned PH_U = 0;
  localparam int unsigned PH_V = 1;
  localparam int unsigned PH_W = 2;
endpackage

// File: rtl/mgg_phase_cell.sv
module mgg_phase_cell (
  input  logic clk,
  input  logic rst,
  input  logic act_high_i,
  input  logic excl_en_i,
  input  logic req_pos_i,
  input  logic req_neg_i,
  input  logic clr_i,
  output logic pin_pos_o,
  output logic pin_neg_o,
  output logic clash_o
);
  logic both_req;
  logic keep_pos;
  logic keep_neg;

  // A phase with both sides requested is dropped when exclusion is enabled.
  always_comb begin
    both_req = req_pos_i & req_neg_i;
    keep_pos = req_pos_i & ~(excl_en_i & both_req);
    keep_neg = req_neg_i & ~(excl_en_i & both_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_pos_o <= 1'b0;
      pin_neg_o <= 1'b0;
      clash_o   <= 1'b0;
    end else begin
      pin_pos_o <= keep_pos ^ ~act_high_i;
      pin_neg_o <= keep_neg ^ ~act_high_i;
      // A new clash in the same cycle wins over the clear.
      clash_o   <= both_req | (clash_o & ~clr_i);
    end
  end

  AST_NO_DUAL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (excl_en_i && req_pos_i && req_neg_i) |=>
      (pin_pos_o == !$past(act_high_i)) && (pin_neg_o == !$past(act_high_i))); // R4

  AST_CLASH_SET: assert property (@(posedge clk) disable iff (rst)
    (req_pos_i && req_neg_i) |=> clash_o); // R6

  AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clash_o && !clr_i) |=> clash_o); // R7
endmodule

// File: rtl/mgg_trip_sync.sv
module mgg_trip_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_n_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic seen_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trip_n_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_o <= 1'b0;
    end else begin
      seen_o <= (arm_i & ~sync_q[LAST]) | (seen_o & ~clr_i);
    end
  end

  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seen_o && !clr_i) |=> seen_o); // R10

  AST_NO_SEEN_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (!seen_o && !arm_i) |=> !seen_o); // R11
endmodule

// File: rtl/motor_gate_guard.sv
module motor_gate_guard #(
  parameter int unsigned NUM_PHASES  = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    act_high_i,
  input  logic                    excl_en_i,
  input  logic                    trip_en_i,
  input  logic                    trip_n_i,
  input  logic [NUM_PHASES-1:0]   req_pos_i,
  input  logic [NUM_PHASES-1:0]   req_neg_i,
  input  logic [NUM_PHASES-1:0]   clr_clash_i,
  input  logic                    clr_trip_i,
  output logic [NUM_PHASES-1:0]   gate_pos_o,
  output logic [NUM_PHASES-1:0]   gate_neg_o,
  output logic [2*NUM_PHASES-1:0] gate_oe_o,
  output logic                    port_sel_o,
  output logic [NUM_PHASES-1:0]   clash_o,
  output logic                    trip_seen_o
);
  import mgg_pkg::*;

  localparam int unsigned NUM_PINS = 2 * NUM_PHASES;

  logic       drive_ready_q;
  logic       trip_cut;
  pad_owner_e owner;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    mgg_phase_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .act_high_i (act_high_i),
      .excl_en_i  (excl_en_i),
      .req_pos_i  (req_pos_i[p]),
      .req_neg_i  (req_neg_i[p]),
      .clr_i      (clr_clash_i[p]),
      .pin_pos_o  (gate_pos_o[p]),
      .pin_neg_o  (gate_neg_o[p]),
      .clash_o    (clash_o[p])
    );
  end

  mgg_trip_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trip (
    .clk      (clk),
    .rst      (rst),
    .trip_n_i (trip_n_i),
    .arm_i    (trip_en_i),
    .clr_i    (clr_trip_i),
    .seen_o   (trip_seen_o)
  );

  // Enables come up one edge after reset ends.
  always_ff @(posedge clk) begin
    if (rst) drive_ready_q <= 1'b0;
    else     drive_ready_q <= 1'b1;
  end

  // The trip path is unclocked: it gates the enables directly.
  always_comb begin
    trip_cut   = trip_en_i & ~trip_n_i;
    owner      = (~trip_en_i & ~trip_n_i) ? OWN_PORT : OWN_STAGE;
    port_sel_o = (owner == OWN_PORT);
    gate_oe_o  = {NUM_PINS{drive_ready_q & ~trip_cut}};
  end

  AST_HIZ_ON_TRIP: assert property (@(posedge clk) disable iff (rst)
    (trip_en_i && !trip_n_i) |-> (gate_oe_o == '0)); // R8

  AST_PORT_KEEPS_OE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && port_sel_o) |-> (gate_oe_o == '1)); // R9
endmodule

// File: tb/sim_motor_gate_guard.sv
module sim_motor_gate_guard;
  logic       clk = 1'b0;
  logic       rst;
  logic       act_high_i, excl_en_i, trip_en_i, trip_n_i, clr_trip_i;
  logic [2:0] req_pos_i, req_neg_i, clr_clash_i;
  logic [2:0] gate_pos_o, gate_neg_o, clash_o;
  logic [5:0] gate_oe_o;
  logic       port_sel_o, trip_seen_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  motor_gate_guard u0 (
    .clk(clk), .rst(rst), .act_high_i(act_high_i), .excl_en_i(excl_en_i),
    .trip_en_i(trip_en_i), .trip_n_i(trip_n_i), .req_pos_i(req_pos_i),
    .req_neg_i(req_neg_i), .clr_clash_i(clr_clash_i), .clr_trip_i(clr_trip_i),
    .gate_pos_o(gate_pos_o), .gate_neg_o(gate_neg_o), .gate_oe_o(gate_oe_o),
    .port_sel_o(port_sel_o), .clash_o(clash_o), .trip_seen_o(trip_seen_o)
  );

  // {act, excl, req_pos, req_neg, exp_pos, exp_neg}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b1, 3'b001, 3'b000, 3'b001, 3'b000},  // R2
    {1'b1, 1'b1, 3'b010, 3'b100, 3'b010, 3'b100},  // R2
    {1'b1, 1'b1, 3'b011, 3'b001, 3'b010, 3'b000},  // R4
    {1'b1, 1'b0, 3'b011, 3'b001, 3'b011, 3'b001},  // R5
    {1'b0, 1'b1, 3'b001, 3'b010, 3'b110, 3'b101},  // R3
    {1'b0, 1'b1, 3'b111, 3'b111, 3'b111, 3'b111},  // R4 active low
    {1'b0, 1'b0, 3'b101, 3'b101, 3'b010, 3'b010},  // R5 active low
    {1'b1, 1'b1, 3'b000, 3'b000, 3'b000, 3'b000}   // R2 idle
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; act_high_i = 1'b1; excl_en_i = 1'b1; trip_en_i = 1'b1;
    trip_n_i = 1'b1; req_pos_i = '0; req_neg_i = '0; clr_clash_i = '0; clr_trip_i = 1'b0;
    step(); step();
    chk("R1 pins", {2'b0, gate_pos_o, gate_neg_o}, 8'h00);
    chk("R1 oe", {2'b0, gate_oe_o}, 8'h00);
    chk("R1 flags", {4'b0, clash_o, trip_seen_o}, 8'h00);
    rst = 1'b0;
    step();
    chk("R1 oe after reset", {2'b0, gate_oe_o}, 8'h3f);
    chk("R9 port_sel idle", {7'b0, port_sel_o}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      {act_high_i, excl_en_i, req_pos_i, req_neg_i} = VEC[i][13:6];
      step();
      chk($sformatf("R2-5 vec%0d pos", i), {5'b0, gate_pos_o}, {5'b0, VEC[i][5:3]});
      chk($sformatf("R2-5 vec%0d neg", i), {5'b0, gate_neg_o}, {5'b0, VEC[i][2:0]});
    end
    chk("R6 clash all phases", {5'b0, clash_o}, 8'h07);

    // R7 clear one phase
    clr_clash_i = 3'b010; step(); clr_clash_i = '0;
    chk("R7 clear V", {5'b0, clash_o}, 8'h05);
    // R7 set wins over clear on U, R6 on V with exclusion off
    excl_en_i = 1'b0; req_pos_i = 3'b011; req_neg_i = 3'b011; clr_clash_i = 3'b001;
    step();
    req_pos_i = '0; req_neg_i = '0; clr_clash_i = '0; excl_en_i = 1'b1;
    chk("R7 set wins", {5'b0, clash_o}, 8'h07);
    step();
    chk("R6 sticky", {5'b0, clash_o}, 8'h07);
    clr_clash_i = 3'b111; step(); clr_clash_i = '0;
    chk("R7 clear all", {5'b0, clash_o}, 8'h00);

    // R8 / R10 armed trip
    trip_en_i = 1'b1; trip_n_i = 1'b0; #1;
    chk("R8 oe cut", {2'b0, gate_oe_o}, 8'h00);
    chk("R9 no port_sel when armed", {7'b0, port_sel_o}, 8'h00);
    @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet at edge 2", {7'b0, trip_seen_o}, 8'h00);
    @(posedge clk); #1;
    chk("R10 set at edge 3", {7'b0, trip_seen_o}, 8'h01);
    step();
    trip_n_i = 1'b1; #1;
    chk("R8 oe restored", {2'b0, gate_oe_o}, 8'h3f);
    step(); step(); step();
    chk("R10 sticky", {7'b0, trip_seen_o}, 8'h01);
    clr_trip_i = 1'b1; step(); clr_trip_i = 1'b0;
    chk("R10 cleared", {7'b0, trip_seen_o}, 8'h00);

    // R9 / R11 disarmed trip
    trip_en_i = 1'b0; trip_n_i = 1'b0; #1;
    chk("R9 port_sel", {7'b0, port_sel_o}, 8'h01);
    chk("R9 oe kept", {2'b0, gate_oe_o}, 8'h3f);
    step(); step(); step(); step();
    chk("R11 no status", {7'b0, trip_seen_o}, 8'h00);
    trip_n_i = 1'b1; #1;
    chk("R9 port_sel released", {7'b0, port_sel_o}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule